// File: doc/BRIEF.md
# Serial Control Port with Programmable Latch Pins

This block is the control port of a codec-style device. A host selects it by pulling the active-low select line down and then clocks in a one-byte instruction followed by one data byte. The serial clock has no fixed relation to the device clock. The select, clock and data inputs are therefore passed through two-flop synchronizers, and every serial edge is detected in the device clock domain.

Three registers sit behind the port. The first is a mode register that holds the control bits for gain, hybrid balance, amplifier and timing. The second is a direction register that makes each latch pin an input or an output. The third is a latch register. Its output bits drive the latch pins, and its input bits capture the pin levels whenever a write completes. A power bit in every instruction powers the device up or down.

For a read, the port shifts out the addressed register on a separate serial output. It also raises an enable that lets that output share a wire with the serial input. Master reset and power-on both put the device into power-down, with every latch pin set as an input.

Top module: `serial_ctrl_port`

## Requirements
- R1: While `masterReset` is high, and after it falls, the outputs show their initial values until the first instruction. These are `powerDown`=1, `latchOe`=0, `latchOut`=0, `ctrlReg`=`CTRL_INIT` (default 0) and `cdoEn`=0. A reset pulse in mid-operation restores the same values.
- R2: Bits are taken MSB first on rising `cclk` edges, and only while `csN` is low. The instruction byte is decoded as follows:
  - Bits [7:6] pick the target: 00 mode register, 01 direction register, 10 latch register, 11 no register.
  - Bit 5 is 1 for a read and 0 for a write.
  - Bit 4 is 1 for power-up and 0 for power-down.
  - Bits [3:0] are ignored.
- R3: The power bit takes effect on the 8th rising edge, whatever the target. While the device is powered down, the mode register can be written and keeps its new value, and the device stays powered down.
- R4: A write is committed on the 16th rising edge. A write to the direction register sets `latchOe` to data[LATCH_W-1:0], where 1 means output. Higher data bits are dropped.
- R5: A write to the latch register loads the data bits into the output-configured bits of the latch register. `latchOut` drives those register bits on the output pins and is 0 on the input pins.
- R6: Every committed write samples `latchIn` into the input-configured bits of the latch register. This applies to every target, including 11. It uses the direction that was in effect before that write.
- R7: For a read, `cdoEn` rises after the 8th rising edge and stays high until `csN` goes high. The addressed register is zero-extended to 8 bits and sent MSB first on `cdo`. Each bit changes on a falling edge, starting with the falling edge after the 8th rising edge.
- R8: Two cases leave every register unchanged:
  - `csN` rises before the 16th rising edge, so the byte is incomplete and discarded.
  - `cclk` toggles while `csN` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| masterReset | input | 1 | Active-high asynchronous reset, also used for power-on |
| csN | input | 1 | Active-low select of the serial port |
| cclk | input | 1 | Serial clock, asynchronous to clk |
| cdi | input | 1 | Serial data in |
| cdo | output | 1 | Serial data out |
| cdoEn | output | 1 | Drive enable for cdo when it shares a wire with cdi |
| latchIn | input | LATCH_W | Levels sensed on the latch pins |
| latchOut | output | LATCH_W | Values driven on the latch pins |
| latchOe | output | LATCH_W | Per-pin output enable, 1 = output |
| ctrlReg | output | 8 | Mode bits for gain, balance, amplifier and timing |
| powerDown | output | 1 | 1 while the device is powered down |

## Verification
The bench uses the default parameters: LATCH_W=6 and CTRL_INIT=0. With six latch bits, a direction write of 0xFF keeps only 0x3F. Reads of the direction and latch registers come back with two zero bits at the top, so truncation and zero-extension are both checked. A zero initial mode register makes the reset value easy to tell apart from the values written later.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    TGT_CTRL  = 2'b00,
    TGT_DIR   = 2'b01,
    TGT_LATCH = 2'b10,
    TGT_NONE  = 2'b11
  } tgt_e;

  // strobes from the serial control FSM to the register datapath
  typedef struct packed {
    logic              wrStb;
    logic              rdLoad;
    logic              outShift;
    logic              pwrStb;
    logic              pwrUp;
    tgt_e              tgt;
    logic [BYTE_W-1:0] data;
  } strobe_t;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int N = 1,
  parameter logic [N-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic meta, stage;
    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        meta  <= RST[b];
        stage <= RST[b];
      end else begin
        meta  <= din[b];
        stage <= meta;
      end
    end
    assign dout[b] = stage;
  end
endmodule

// File: rtl/scp_ctrl.sv
module scp_ctrl
  import scp_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    csN,
  input  logic    cclk,
  input  logic    cdi,
  output strobe_t stb,
  output logic    cdoEn
);
  localparam int CNT_W = $clog2(2 * BYTE_W + 1);
  localparam logic [CNT_W-1:0] INSTR_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST  = CNT_W'(2 * BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_MAX    = CNT_W'(2 * BYTE_W);

  logic csS, cclkS, cdiS, cclkP;
  logic rise, fall;
  logic [CNT_W-1:0] cnt;
  logic [BYTE_W-2:0] sr;
  tgt_e tgtR;
  logic isRead, rdActive;

  scp_sync #(.N(3), .RST(3'b100)) i_sync (
    .clk (clk),
    .rst (rst),
    .din ({csN, cclk, cdi}),
    .dout({csS, cclkS, cdiS})
  );

  assign rise = cclkS & ~cclkP & ~csS;
  assign fall = ~cclkS & cclkP & ~csS;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cclkP    <= 1'b0;
      cnt      <= '0;
      sr       <= '0;
      tgtR     <= TGT_NONE;
      isRead   <= 1'b0;
      rdActive <= 1'b0;
    end else begin
      cclkP <= cclkS;
      if (csS) begin
        cnt      <= '0;
        rdActive <= 1'b0;
      end else if (rise && cnt < CNT_MAX) begin
        sr  <= {sr[BYTE_W-3:0], cdiS};
        cnt <= cnt + 1'b1;
        if (cnt == INSTR_LAST) begin
          tgtR   <= tgt_e'(sr[6:5]);
          isRead <= sr[4];
          if (sr[4]) rdActive <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    stb.data     = {sr, cdiS};
    stb.pwrStb   = rise && (cnt == INSTR_LAST);
    stb.pwrUp    = sr[3];
    stb.rdLoad   = rise && (cnt == INSTR_LAST) && sr[4];
    stb.tgt      = (cnt == INSTR_LAST) ? tgt_e'(sr[6:5]) : tgtR;
    stb.wrStb    = rise && (cnt == DATA_LAST) && !isRead;
    stb.outShift = fall && rdActive;
  end

  assign cdoEn = rdActive;

  a_r7_release_on_deselect: assert property (@(posedge clk) disable iff (rst)
    csS |=> !rdActive);
  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_MAX);
  a_r8_no_commit_deselected: assert property (@(posedge clk) disable iff (rst)
    csS |-> !stb.wrStb && !stb.pwrStb);
endmodule

// File: rtl/scp_regs.sv
module scp_regs
  import scp_pkg::*;
#(
  parameter int LATCH_W = 6,
  parameter logic [BYTE_W-1:0] CTRL_INIT = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            stb,
  input  logic [LATCH_W-1:0] latchIn,
  output logic [LATCH_W-1:0] latchOut,
  output logic [LATCH_W-1:0] latchOe,
  output logic [BYTE_W-1:0]  ctrlReg,
  output logic               powerDown,
  output logic               cdo
);
  logic [LATCH_W-1:0] dirReg, latchReg, latchNext;
  logic [BYTE_W-1:0]  dirExt, latchExt, rdVal, outSr;
  logic               cdoBit;

  // per pin: inputs capture the pin, outputs take data on a latch write
  for (genvar b = 0; b < LATCH_W; b++) begin : g_pin
    assign latchNext[b] = !dirReg[b] ? latchIn[b]
                        : (stb.tgt == TGT_LATCH) ? stb.data[b] : latchReg[b];
  end

  always_comb begin
    dirExt   = '0;
    latchExt = '0;
    dirExt[LATCH_W-1:0]   = dirReg;
    latchExt[LATCH_W-1:0] = latchReg;
    case (stb.tgt)
      TGT_CTRL:  rdVal = ctrlReg;
      TGT_DIR:   rdVal = dirExt;
      TGT_LATCH: rdVal = latchExt;
      default:   rdVal = '0;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      dirReg    <= '0;
      latchReg  <= '0;
      ctrlReg   <= CTRL_INIT;
      powerDown <= 1'b1;
      outSr     <= '0;
      cdoBit    <= 1'b0;
    end else begin
      if (stb.pwrStb) powerDown <= !stb.pwrUp;
      if (stb.wrStb) begin
        latchReg <= latchNext;
        if (stb.tgt == TGT_DIR)  dirReg  <= stb.data[LATCH_W-1:0];
        if (stb.tgt == TGT_CTRL) ctrlReg <= stb.data;
      end
      if (stb.rdLoad) begin
        outSr <= rdVal;
      end else if (stb.outShift) begin
        cdoBit <= outSr[BYTE_W-1];
        outSr  <= {outSr[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign latchOe  = dirReg;
  assign latchOut = latchReg & dirReg;
  assign cdo      = cdoBit;

  a_r4_dir_hold: assert property (@(posedge clk) disable iff (rst)
    !(stb.wrStb && stb.tgt == TGT_DIR) |=> $stable(latchOe));
  a_r3_power_hold: assert property (@(posedge clk) disable iff (rst)
    !stb.pwrStb |=> $stable(powerDown));
  a_r4_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
    !(stb.wrStb && stb.tgt == TGT_CTRL) |=> $stable(ctrlReg));
endmodule

// File: rtl/serial_ctrl_port.sv
module serial_ctrl_port
  import scp_pkg::*;
#(
  parameter int LATCH_W = 6,
  parameter logic [7:0] CTRL_INIT = 8'h00
) (
  input  logic               clk,
  input  logic               masterReset,
  input  logic               csN,
  input  logic               cclk,
  input  logic               cdi,
  output logic               cdo,
  output logic               cdoEn,
  input  logic [LATCH_W-1:0] latchIn,
  output logic [LATCH_W-1:0] latchOut,
  output logic [LATCH_W-1:0] latchOe,
  output logic [7:0]         ctrlReg,
  output logic               powerDown
);
  strobe_t stb;

  scp_ctrl i_ctrl (
    .clk  (clk),
    .rst  (masterReset),
    .csN  (csN),
    .cclk (cclk),
    .cdi  (cdi),
    .stb  (stb),
    .cdoEn(cdoEn)
  );

  scp_regs #(.LATCH_W(LATCH_W), .CTRL_INIT(CTRL_INIT)) i_regs (
    .clk      (clk),
    .rst      (masterReset),
    .stb      (stb),
    .latchIn  (latchIn),
    .latchOut (latchOut),
    .latchOe  (latchOe),
    .ctrlReg  (ctrlReg),
    .powerDown(powerDown),
    .cdo      (cdo)
  );
endmodule

// File: tb/test_serial_ctrl_port.sv
module test_serial_ctrl_port;
  logic clk = 1'b0;
  logic masterReset = 1'b1;
  logic csN = 1'b1, cclk = 1'b0, cdi = 1'b0;
  logic cdo, cdoEn, powerDown;
  logic [5:0] latchIn = '0, latchOut, latchOe;
  logic [7:0] ctrlReg;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  serial_ctrl_port i_serial_ctrl_port (
    .clk(clk), .masterReset(masterReset), .csN(csN), .cclk(cclk), .cdi(cdi),
    .cdo(cdo), .cdoEn(cdoEn), .latchIn(latchIn), .latchOut(latchOut),
    .latchOe(latchOe), .ctrlReg(ctrlReg), .powerDown(powerDown)
  );

  // {instr, data, expOe, expOut, expPd, expCtrl}
  localparam logic [47:0] VEC [6] = '{
    {8'h00, 8'h5A, 8'h00, 8'h00, 8'h01, 8'h5A},
    {8'h50, 8'h07, 8'h07, 8'h00, 8'h00, 8'h5A},
    {8'h90, 8'h3F, 8'h07, 8'h07, 8'h00, 8'h5A},
    {8'h90, 8'h02, 8'h07, 8'h02, 8'h00, 8'h5A},
    {8'hC0, 8'hFF, 8'h07, 8'h02, 8'h01, 8'h5A},
    {8'h50, 8'hFF, 8'h3F, 8'h02, 8'h00, 8'h5A}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] instr, input logic [7:0] data, input int nbits,
                      output logic [7:0] rd, output logic enSeen);
    rd = '0;
    enSeen = 1'b0;
    csN = 1'b0;
    waitClk(4);
    for (int i = 0; i < nbits; i++) begin
      cdi = (i < 8) ? instr[7 - i] : data[15 - i];
      waitClk(4);
      if (i == 8) enSeen = cdoEn;
      cclk = 1'b1;
      waitClk(4);
      if (i >= 8) rd[15 - i] = cdo;
      waitClk(4);
      cclk = 1'b0;
      waitClk(4);
    end
    waitClk(4);
    csN = 1'b1;
    waitClk(6);
  endtask

  task automatic checkDefaults(input string req);
    check({req, " powerDown"}, {7'b0, powerDown}, 8'h01);
    check({req, " latchOe"}, {2'b0, latchOe}, 8'h00);
    check({req, " latchOut"}, {2'b0, latchOut}, 8'h00);
    check({req, " ctrlReg"}, ctrlReg, 8'h00);
    check({req, " cdoEn"}, {7'b0, cdoEn}, 8'h00);
  endtask

  initial begin
    logic [7:0] rd;
    logic en;
    waitClk(2);
    checkDefaults("R1 during reset");
    waitClk(3);
    masterReset = 1'b0;
    waitClk(5);
    checkDefaults("R1 after reset");

    // R2 R3 R4 R5 R6: table walk
    for (int i = 0; i < 6; i++) begin
      xfer(VEC[i][47:40], VEC[i][39:32], 16, rd, en);
      check($sformatf("R4 vec%0d latchOe", i), {2'b0, latchOe}, VEC[i][31:24]);
      check($sformatf("R5 vec%0d latchOut", i), {2'b0, latchOut}, VEC[i][23:16]);
      check($sformatf("R3 vec%0d powerDown", i), {7'b0, powerDown}, VEC[i][15:8]);
      check($sformatf("R2 vec%0d ctrlReg", i), ctrlReg, VEC[i][7:0]);
    end

    // R7: read direction, zero-extended
    xfer(8'h70, 8'h00, 16, rd, en);
    check("R7 read dir padded", rd, 8'h3F);
    check("R7 cdoEn released", {7'b0, cdoEn}, 8'h00);

    xfer(8'h50, 8'h07, 16, rd, en);
    check("R4 dir back to 07", {2'b0, latchOe}, 8'h07);

    // R6: inputs sampled on a latch write
    latchIn = 6'b101010;
    xfer(8'h90, 8'h05, 16, rd, en);
    check("R5 latchOut after mixed write", {2'b0, latchOut}, 8'h05);
    xfer(8'hB0, 8'h00, 16, rd, en);
    check("R6 read latch after latch write", rd, 8'h2D);
    check("R7 cdoEn during read", {7'b0, en}, 8'h01);
    check("R7 cdoEn after deselect", {7'b0, cdoEn}, 8'h00);

    // R6: inputs sampled on a mode register write
    latchIn = 6'b010000;
    xfer(8'h10, 8'h33, 16, rd, en);
    check("R4 ctrl write", ctrlReg, 8'h33);
    xfer(8'hB0, 8'h00, 16, rd, en);
    check("R6 read latch after ctrl write", rd, 8'h15);
    xfer(8'h30, 8'h00, 16, rd, en);
    check("R7 read ctrl", rd, 8'h33);

    // R8: incomplete byte discarded
    xfer(8'h90, 8'hFF, 12, rd, en);
    check("R8 incomplete latch write", {2'b0, latchOut}, 8'h05);
    xfer(8'h50, 8'h3F, 15, rd, en);
    check("R8 incomplete dir write", {2'b0, latchOe}, 8'h07);

    // R8: clock edges while deselected
    cdi = 1'b1;
    for (int i = 0; i < 20; i++) begin
      cclk = 1'b1; waitClk(8);
      cclk = 1'b0; waitClk(8);
    end
    check("R8 deselected clocks oe", {2'b0, latchOe}, 8'h07);
    xfer(8'h70, 8'h00, 16, rd, en);
    check("R8 read dir after deselected clocks", rd, 8'h07);
    check("R3 power-up held", {7'b0, powerDown}, 8'h00);

    // R1: reset pulse mid-run
    masterReset = 1'b1;
    waitClk(3);
    masterReset = 1'b0;
    waitClk(5);
    checkDefaults("R1 mid-run reset");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule